// File: doc/BRIEF.md
# Low-Power Clock Mode Controller

This block decides which clock domains of a small microcontroller receive clock enables and at what rate. The system clock can come from one of three sources. The fast source runs on every cycle of the reference clock. The main source is that rate divided by two. The slow source is the sub-oscillator tick divided by four. The block drives per-cycle enable strobes for the CPU and the peripherals. It drives level enables for the timebase timer, the watch timer, the PLL, the main oscillator and the sub-oscillator. Everything is synchronous logic on one reference clock. The oscillators, the PLL and the glitch-free clock muxes sit outside the block.

Software selects a run or standby mode by writing a 4-bit command with a strobe. Each standby level keeps a smaller set of domains alive and remembers the source that was in use when it was entered. A wake-up pulse returns the block to that run mode. When leaving the deepest level, the block first counts a programmable number of sub-oscillator ticks so that the oscillators can stabilise. An intermittent variant of each run mode gates the CPU strobe down to the cycles flagged as bus accesses. Switches into or out of the slow source wait for the divided-tick boundary.

Top module: `lp_clk_ctrl`

## Requirements
- R1: Mode code 0 (fast source, `mode_o`=0, `src_o`=0): `cpu_en_o` and `per_en_o` are high on every cycle, and `pll_en_o`, `mosc_en_o`, `sosc_en_o`, `tbt_en_o`, `watch_en_o` are all high.
- R2: Mode code 1 (main source, `src_o`=1, the reset mode): `cpu_en_o` and `per_en_o` are high on every second cycle, `pll_en_o` is low, and the other level enables are high.
- R3: Mode code 2 (slow source, `src_o`=2): `cpu_en_o` and `per_en_o` are high only on every fourth `sub_tick_i` pulse counted from reset, while `pll_en_o` and `mosc_en_o` are low.
- R4: Code 3 (sleep) holds `cpu_en_o` low. `per_en_o` keeps the rate of the source active at entry, `src_o` stays unchanged, and the level enables stay as in run.
- R5: Code 4 (timebase) keeps only `tbt_en_o`, `watch_en_o`, `sosc_en_o` high, plus `mosc_en_o` unless the slow source is active. `cpu_en_o`, `per_en_o` and `pll_en_o` are low.
- R6: Code 5 (watch) keeps only `watch_en_o` and `sosc_en_o` high.
- R7: Code 6 (stop) drives all seven enables low, `sosc_en_o` included.
- R8: Codes 8, 9 and 10 are the intermittent forms of codes 0, 1 and 2. `per_en_o` keeps the source rate, and `cpu_en_o` is high only when the source tick and `acc_i` are both high.
- R9: Undefined codes (7 and 11 to 15) are ignored, and any command written while in a standby mode is ignored. `mode_o` is held in both cases.
- R10: A `wake_i` pulse in sleep, timebase or watch returns the block to the run mode held before entry, one cycle later.
- R11: A `wake_i` pulse in stop raises `busy_o`. It re-enables the oscillators for the source at entry while the functional enables stay low. The block returns to run on the N-th `sub_tick_i` pulse after that, where N = max(`stab_i`, 16). `busy_o` is high only during this wait.
- R12: A source change into or out of the slow source takes effect on the edge of the `sub_tick_i` pulse that completes a group of four. Changes between the fast and main sources take effect on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Mode command strobe |
| cmd_i | input | 4 | Mode command code |
| wake_i | input | 1 | Wake-up pulse |
| acc_i | input | 1 | Current cycle is a CPU bus access |
| sub_tick_i | input | 1 | One pulse per sub-oscillator period |
| stab_i | input | CNT_W | Stabilisation count in sub ticks |
| cpu_en_o | output | 1 | CPU clock enable strobe |
| per_en_o | output | 1 | Peripheral clock enable strobe |
| tbt_en_o | output | 1 | Timebase timer enable |
| watch_en_o | output | 1 | Watch timer enable |
| pll_en_o | output | 1 | PLL enable |
| mosc_en_o | output | 1 | Main oscillator enable |
| sosc_en_o | output | 1 | Sub-oscillator enable |
| mode_o | output | 4 | Current mode code |
| src_o | output | 2 | Active clock source |
| busy_o | output | 1 | Stabilisation wait in progress |

## Verification
A vector walk steps through each defined command from the fast and main sources. Its rows include undefined codes and commands issued in standby, which must leave the mode unchanged, and each standby row is followed by a wake-up. Strobe counts over fixed windows separate the three source rates. The same counts separate sleep and intermittent gating from plain run, with the access flag tied low and then high. Slow-source switches are issued off the four-tick boundary, so an early switch is caught. Two stop exits, one above and one below the minimum count, check the stabilisation length and its clamp.

// File: rtl/lp_clk_pkg.sv
package lp_clk_pkg;

  typedef enum logic [1:0] {
    SRC_PLL  = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_SUB  = 2'd2
  } src_e;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_SLEEP,
    ST_TBT,
    ST_WATCH,
    ST_STOP,
    ST_WAKE
  } st_e;

  localparam logic [3:0] CODE_SLEEP = 4'd3;
  localparam logic [3:0] CODE_TBT   = 4'd4;
  localparam logic [3:0] CODE_WATCH = 4'd5;
  localparam logic [3:0] CODE_STOP  = 4'd6;

  typedef struct packed {
    logic cpu;
    logic per;
    logic tbt;
    logic wtc;
    logic pll;
    logic mosc;
    logic sosc;
  } en_t;

  // run codes: 0,1,2 plain; 8,9,10 intermittent
  function automatic logic is_run_code(logic [3:0] c);
    return (c[1:0] != 2'd3) && (c[2] == 1'b0);
  endfunction

  function automatic logic is_stby_code(logic [3:0] c);
    return (c == CODE_SLEEP) || (c == CODE_TBT) ||
           (c == CODE_WATCH) || (c == CODE_STOP);
  endfunction

endpackage

// File: rtl/lp_tick_gen.sv
module lp_tick_gen #(
  parameter int MAIN_DIV = 2,
  parameter int SUB_DIV  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sub_tick_i,
  output logic main_tick_o,
  output logic sub_div_tick_o
);

  if (MAIN_DIV > 1) begin : g_main
    localparam int MW = $clog2(MAIN_DIV);
    localparam logic [MW-1:0] MTOP = MW'(MAIN_DIV - 1);
    logic [MW-1:0] ph_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          ph_q <= '0;
      else if (ph_q == MTOP) ph_q <= '0;
      else                   ph_q <= ph_q + MW'(1);
    end
    assign main_tick_o = (ph_q == MTOP);
  end else begin : g_main_pass
    assign main_tick_o = 1'b1;
  end

  if (SUB_DIV > 1) begin : g_sub
    localparam int SW = $clog2(SUB_DIV);
    localparam logic [SW-1:0] STOP_PH = SW'(SUB_DIV - 1);
    logic [SW-1:0] ph_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ph_q <= '0;
      else if (sub_tick_i) ph_q <= (ph_q == STOP_PH) ? '0 : ph_q + SW'(1);
    end
    assign sub_div_tick_o = sub_tick_i && (ph_q == STOP_PH);
  end else begin : g_sub_pass
    assign sub_div_tick_o = sub_tick_i;
  end

endmodule

// File: rtl/lp_mode_fsm.sv
module lp_mode_fsm
  import lp_clk_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int STAB_MIN = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [3:0]       cmd_i,
  input  logic             wake_i,
  input  logic             sub_tick_i,
  input  logic             sub_div_tick_i,
  input  logic [CNT_W-1:0] stab_i,
  output st_e              st_o,
  output src_e             src_o,
  output logic             intm_o,
  output logic [3:0]       mode_o
);

  localparam logic [CNT_W-1:0] LIM_MIN = CNT_W'(STAB_MIN);

  st_e              st_q, st_d;
  src_e             src_q, src_d, pend_src_q, pend_src_d, new_src;
  logic             intm_q, intm_d, pend_intm_q, pend_intm_d;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, lim;

  assign lim     = (stab_i < LIM_MIN) ? LIM_MIN : stab_i;
  assign new_src = src_e'(cmd_i[1:0]);

  always_comb begin
    st_d        = st_q;
    src_d       = src_q;
    intm_d      = intm_q;
    pend_d      = pend_q;
    pend_src_d  = pend_src_q;
    pend_intm_d = pend_intm_q;
    cnt_d       = cnt_q;
    unique case (st_q)
      ST_RUN: begin
        if (cmd_we_i && is_stby_code(cmd_i)) begin
          pend_d = 1'b0;
          unique case (cmd_i)
            CODE_SLEEP: st_d = ST_SLEEP;
            CODE_TBT:   st_d = ST_TBT;
            CODE_WATCH: st_d = ST_WATCH;
            default:    st_d = ST_STOP;
          endcase
        end else if (cmd_we_i && is_run_code(cmd_i)) begin
          // slow-source moves wait for the divided boundary
          if ((new_src != src_q) && ((new_src == SRC_SUB) || (src_q == SRC_SUB))) begin
            pend_d      = 1'b1;
            pend_src_d  = new_src;
            pend_intm_d = cmd_i[3];
          end else begin
            pend_d = 1'b0;
            src_d  = new_src;
            intm_d = cmd_i[3];
          end
        end else if (pend_q && sub_div_tick_i) begin
          pend_d = 1'b0;
          src_d  = pend_src_q;
          intm_d = pend_intm_q;
        end
      end
      ST_SLEEP, ST_TBT, ST_WATCH: if (wake_i) st_d = ST_RUN;
      ST_STOP: if (wake_i) begin
        st_d  = ST_WAKE;
        cnt_d = '0;
      end
      ST_WAKE: if (sub_tick_i) begin
        if (cnt_q == lim - CNT_W'(1)) begin
          st_d  = ST_RUN;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_RUN;
      src_q       <= SRC_MAIN;
      intm_q      <= 1'b0;
      pend_q      <= 1'b0;
      pend_src_q  <= SRC_MAIN;
      pend_intm_q <= 1'b0;
      cnt_q       <= '0;
    end else begin
      st_q        <= st_d;
      src_q       <= src_d;
      intm_q      <= intm_d;
      pend_q      <= pend_d;
      pend_src_q  <= pend_src_d;
      pend_intm_q <= pend_intm_d;
      cnt_q       <= cnt_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_RUN:   mode_o = {intm_q, 1'b0, src_q};
      ST_SLEEP: mode_o = CODE_SLEEP;
      ST_TBT:   mode_o = CODE_TBT;
      ST_WATCH: mode_o = CODE_WATCH;
      default:  mode_o = CODE_STOP;
    endcase
  end

  assign st_o   = st_q;
  assign src_o  = src_q;
  assign intm_o = intm_q;

endmodule

// File: rtl/lp_en_decode.sv
module lp_en_decode
  import lp_clk_pkg::*;
(
  input  st_e  st_i,
  input  src_e src_i,
  input  logic intm_i,
  input  logic acc_i,
  input  logic main_tick_i,
  input  logic sub_div_tick_i,
  output en_t  en_o
);

  logic base, pll_on, mosc_on;

  always_comb begin
    unique case (src_i)
      SRC_PLL:  base = 1'b1;
      SRC_MAIN: base = main_tick_i;
      SRC_SUB:  base = sub_div_tick_i;
      default:  base = 1'b0;
    endcase
  end

  assign pll_on  = (src_i == SRC_PLL);
  assign mosc_on = (src_i != SRC_SUB);

  always_comb begin
    en_o = '0;
    unique case (st_i)
      ST_RUN: begin
        en_o.cpu  = base && (!intm_i || acc_i);
        en_o.per  = base;
        en_o.tbt  = 1'b1;
        en_o.wtc  = 1'b1;
        en_o.pll  = pll_on;
        en_o.mosc = mosc_on;
        en_o.sosc = 1'b1;
      end
      ST_SLEEP: begin
        en_o.per  = base;
        en_o.tbt  = 1'b1;
        en_o.wtc  = 1'b1;
        en_o.pll  = pll_on;
        en_o.mosc = mosc_on;
        en_o.sosc = 1'b1;
      end
      ST_TBT: begin
        en_o.tbt  = 1'b1;
        en_o.wtc  = 1'b1;
        en_o.mosc = mosc_on;
        en_o.sosc = 1'b1;
      end
      ST_WATCH: begin
        en_o.wtc  = 1'b1;
        en_o.sosc = 1'b1;
      end
      ST_WAKE: begin
        en_o.pll  = pll_on;
        en_o.mosc = mosc_on;
        en_o.sosc = 1'b1;
      end
      default: en_o = '0;
    endcase
  end

endmodule

// File: rtl/lp_clk_ctrl.sv
module lp_clk_ctrl
  import lp_clk_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int STAB_MIN = 16,
  parameter int MAIN_DIV = 2,
  parameter int SUB_DIV  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [3:0]       cmd_i,
  input  logic             wake_i,
  input  logic             acc_i,
  input  logic             sub_tick_i,
  input  logic [CNT_W-1:0] stab_i,
  output logic             cpu_en_o,
  output logic             per_en_o,
  output logic             tbt_en_o,
  output logic             watch_en_o,
  output logic             pll_en_o,
  output logic             mosc_en_o,
  output logic             sosc_en_o,
  output logic [3:0]       mode_o,
  output logic [1:0]       src_o,
  output logic             busy_o
);

  logic main_tick, sub_div_tick, intm;
  st_e  st;
  src_e src;
  en_t  en;

  lp_tick_gen #(.MAIN_DIV(MAIN_DIV), .SUB_DIV(SUB_DIV)) u_tick (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sub_tick_i     (sub_tick_i),
    .main_tick_o    (main_tick),
    .sub_div_tick_o (sub_div_tick)
  );

  lp_mode_fsm #(.CNT_W(CNT_W), .STAB_MIN(STAB_MIN)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cmd_we_i       (cmd_we_i),
    .cmd_i          (cmd_i),
    .wake_i         (wake_i),
    .sub_tick_i     (sub_tick_i),
    .sub_div_tick_i (sub_div_tick),
    .stab_i         (stab_i),
    .st_o           (st),
    .src_o          (src),
    .intm_o         (intm),
    .mode_o         (mode_o)
  );

  lp_en_decode u_dec (
    .st_i           (st),
    .src_i          (src),
    .intm_i         (intm),
    .acc_i          (acc_i),
    .main_tick_i    (main_tick),
    .sub_div_tick_i (sub_div_tick),
    .en_o           (en)
  );

  assign cpu_en_o   = en.cpu;
  assign per_en_o   = en.per;
  assign tbt_en_o   = en.tbt;
  assign watch_en_o = en.wtc;
  assign pll_en_o   = en.pll;
  assign mosc_en_o  = en.mosc;
  assign sosc_en_o  = en.sosc;
  assign src_o      = src;
  assign busy_o     = (st == ST_WAKE);

endmodule

// File: rtl/lp_clk_ctrl_chk.sv
module lp_clk_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_we_i,
  input logic [3:0] cmd_i,
  input logic       wake_i,
  input logic       acc_i,
  input logic       sub_tick_i,
  input logic       sub_div_tick,
  input logic       cpu_en_o,
  input logic       per_en_o,
  input logic       tbt_en_o,
  input logic       watch_en_o,
  input logic       pll_en_o,
  input logic       mosc_en_o,
  input logic       sosc_en_o,
  input logic [3:0] mode_o,
  input logic [1:0] src_o,
  input logic       busy_o
);

  AST_MAIN_NO_PLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 4'd1) |-> !pll_en_o);  // R2

  AST_SUB_OSC_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 4'd2) |-> (!pll_en_o && !mosc_en_o));  // R3

  AST_SLEEP_CPU_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 4'd3) |-> (!cpu_en_o && tbt_en_o && watch_en_o));  // R4

  AST_TBT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 4'd4) |-> (!cpu_en_o && !per_en_o && !pll_en_o && tbt_en_o && watch_en_o));  // R5

  AST_WATCH_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 4'd5) |-> (watch_en_o && sosc_en_o && !cpu_en_o && !per_en_o &&
                          !tbt_en_o && !pll_en_o && !mosc_en_o));  // R6

  AST_STOP_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 4'd6 && !busy_o) |-> (!cpu_en_o && !per_en_o && !tbt_en_o && !watch_en_o &&
                                     !pll_en_o && !mosc_en_o && !sosc_en_o));  // R7

  AST_INTM_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[3] && cpu_en_o) |-> (acc_i && per_en_o));  // R8

  AST_BAD_CMD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && (cmd_i == 4'd7 || cmd_i > 4'd10) && !sub_tick_i && !wake_i)
      |=> $stable(mode_o));  // R9

  AST_BUSY_IN_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (mode_o == 4'd6 && !cpu_en_o && !per_en_o && sosc_en_o));  // R11

  AST_SUB_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_o != $past(src_o)) && (src_o == 2'd2 || $past(src_o) == 2'd2))
      |-> $past(sub_div_tick));  // R12

endmodule

bind lp_clk_ctrl lp_clk_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_we_i     (cmd_we_i),
  .cmd_i        (cmd_i),
  .wake_i       (wake_i),
  .acc_i        (acc_i),
  .sub_tick_i   (sub_tick_i),
  .sub_div_tick (sub_div_tick),
  .cpu_en_o     (cpu_en_o),
  .per_en_o     (per_en_o),
  .tbt_en_o     (tbt_en_o),
  .watch_en_o   (watch_en_o),
  .pll_en_o     (pll_en_o),
  .mosc_en_o    (mosc_en_o),
  .sosc_en_o    (sosc_en_o),
  .mode_o       (mode_o),
  .src_o        (src_o),
  .busy_o       (busy_o)
);

// File: tb/tb_lp_clk_ctrl.sv
module tb_lp_clk_ctrl;

  localparam int CNT_W = 16;
  localparam int NVEC  = 16;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cmd_we_i = 1'b0;
  logic [3:0]       cmd_i = '0;
  logic             wake_i = 1'b0;
  logic             acc_i = 1'b0;
  logic             sub_tick_i = 1'b0;
  logic [CNT_W-1:0] stab_i = 16'd20;
  logic cpu_en_o, per_en_o, tbt_en_o, watch_en_o, pll_en_o, mosc_en_o, sosc_en_o, busy_o;
  logic [3:0] mode_o;
  logic [1:0] src_o;

  int n_chk = 0, n_err = 0, cpu_cnt = 0, per_cnt = 0, sub_n = 0;

  always #4 clk = ~clk;  // 125 MHz

  lp_clk_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_we_i(cmd_we_i), .cmd_i(cmd_i),
    .wake_i(wake_i), .acc_i(acc_i), .sub_tick_i(sub_tick_i), .stab_i(stab_i),
    .cpu_en_o(cpu_en_o), .per_en_o(per_en_o), .tbt_en_o(tbt_en_o),
    .watch_en_o(watch_en_o), .pll_en_o(pll_en_o), .mosc_en_o(mosc_en_o),
    .sosc_en_o(sosc_en_o), .mode_o(mode_o), .src_o(src_o), .busy_o(busy_o)
  );

  // {wake, cmd, expected mode, expected {tbt,watch,pll,mosc,sosc}}
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b0, 4'd0,  4'd0, 5'b11111},  // R1
    {1'b0, 4'd1,  4'd1, 5'b11011},  // R2
    {1'b0, 4'd0,  4'd0, 5'b11111},  // R1
    {1'b0, 4'd3,  4'd3, 5'b11111},  // R4
    {1'b0, 4'd0,  4'd3, 5'b11111},  // R9 ignored in standby
    {1'b1, 4'd0,  4'd0, 5'b11111},  // R10
    {1'b0, 4'd7,  4'd0, 5'b11111},  // R9
    {1'b0, 4'd4,  4'd4, 5'b11011},  // R5
    {1'b1, 4'd0,  4'd0, 5'b11111},  // R10
    {1'b0, 4'd5,  4'd5, 5'b01001},  // R6
    {1'b1, 4'd0,  4'd0, 5'b11111},  // R10
    {1'b0, 4'd9,  4'd9, 5'b11011},  // R8
    {1'b0, 4'd15, 4'd9, 5'b11011},  // R9
    {1'b0, 4'd1,  4'd1, 5'b11011},  // R2
    {1'b0, 4'd3,  4'd3, 5'b11011},  // R4
    {1'b1, 4'd0,  4'd1, 5'b11011}   // R10
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
  endtask

  task automatic do_cmd(input logic [3:0] c);
    @(negedge clk); cmd_we_i = 1'b1; cmd_i = c; sub_tick_i = 1'b0;
    @(negedge clk); cmd_we_i = 1'b0; #1;
  endtask

  task automatic do_wake;
    @(negedge clk); wake_i = 1'b1; sub_tick_i = 1'b0;
    @(negedge clk); wake_i = 1'b0; #1;
  endtask

  task automatic cyc(input logic st);
    @(negedge clk); sub_tick_i = st; #1;
    if (cpu_en_o) cpu_cnt++;
    if (per_en_o) per_cnt++;
    if (st) sub_n++;
  endtask

  task automatic clr;
    cpu_cnt = 0; per_cnt = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R2 reset mode", 32'(mode_o), 32'd1);
    chk("R11 reset busy", 32'(busy_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    chk("R2 reset pll_en", 32'(pll_en_o), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][13]) do_wake();
      else            do_cmd(VEC[i][12:9]);
      chk("R1-vec mode", 32'(mode_o), 32'(VEC[i][8:5]));
      chk("R5-vec enables", 32'({tbt_en_o, watch_en_o, pll_en_o, mosc_en_o, sosc_en_o}),
          32'(VEC[i][4:0]));
    end

    // R1 rate
    do_cmd(4'd0); clr();
    for (int i = 0; i < 8; i++) cyc(1'b0);
    chk("R1 cpu rate", cpu_cnt, 8);
    chk("R1 per rate", per_cnt, 8);

    // R2 rate
    do_cmd(4'd1); clr();
    for (int i = 0; i < 8; i++) cyc(1'b0);
    chk("R2 cpu rate", cpu_cnt, 4);
    chk("R2 per rate", per_cnt, 4);

    // R8 intermittent
    do_cmd(4'd9); clr(); acc_i = 1'b0;
    for (int i = 0; i < 8; i++) cyc(1'b0);
    chk("R8 cpu no access", cpu_cnt, 0);
    chk("R8 per", per_cnt, 4);
    clr(); acc_i = 1'b1;
    for (int i = 0; i < 8; i++) cyc(1'b0);
    chk("R8 cpu access", cpu_cnt, 4);
    acc_i = 1'b0;

    // R4 sleep from main intermittent
    do_cmd(4'd3); clr();
    for (int i = 0; i < 8; i++) cyc(1'b0);
    chk("R4 cpu off", cpu_cnt, 0);
    chk("R4 per main rate", per_cnt, 4);
    chk("R4 src kept", 32'(src_o), 32'd1);
    do_wake();
    chk("R10 back to 9", 32'(mode_o), 32'd9);

    // R12 into slow source
    do_cmd(4'd1);
    while ((sub_n % 4) != 1) begin cyc(1'b1); cyc(1'b0); end
    do_cmd(4'd2);
    chk("R12 into sub held", 32'(mode_o), 32'd1);
    while ((sub_n % 4) != 3) begin cyc(1'b1); cyc(1'b0); end
    chk("R12 into sub before edge", 32'(mode_o), 32'd1);
    cyc(1'b1); cyc(1'b0);
    chk("R12 into sub at edge", 32'(mode_o), 32'd2);

    // R3 rate in slow source
    clr();
    for (int i = 0; i < 8; i++) begin cyc(1'b1); cyc(1'b0); end
    chk("R3 cpu rate", cpu_cnt, 2);
    chk("R3 per rate", per_cnt, 2);
    chk("R3 osc", 32'({pll_en_o, mosc_en_o, sosc_en_o}), 32'b001);

    // R12 out of slow source
    cyc(1'b1); cyc(1'b0);
    do_cmd(4'd1);
    chk("R12 out sub held", 32'(mode_o), 32'd2);
    while ((sub_n % 4) != 3) begin cyc(1'b1); cyc(1'b0); end
    chk("R12 out sub before edge", 32'(mode_o), 32'd2);
    cyc(1'b1); cyc(1'b0);
    chk("R12 out sub at edge", 32'(mode_o), 32'd1);

    // R7 / R11 stop with count 20
    stab_i = 16'd20;
    do_cmd(4'd6);
    chk("R7 stop mode", 32'(mode_o), 32'd6);
    chk("R7 all off", 32'({cpu_en_o, per_en_o, tbt_en_o, watch_en_o, pll_en_o, mosc_en_o, sosc_en_o}), 32'd0);
    do_cmd(4'd0);
    chk("R9 cmd in stop", 32'(mode_o), 32'd6);
    do_wake();
    chk("R11 busy", 32'(busy_o), 32'd1);
    chk("R11 osc on", 32'({cpu_en_o, per_en_o, pll_en_o, mosc_en_o, sosc_en_o}), 32'b00011);
    for (int i = 0; i < 19; i++) cyc(1'b1);
    cyc(1'b0);
    chk("R11 still busy at 19", 32'(busy_o), 32'd1);
    cyc(1'b1); cyc(1'b0);
    chk("R11 done busy", 32'(busy_o), 32'd0);
    chk("R11 back to main", 32'(mode_o), 32'd1);

    // R11 clamp to 16
    stab_i = 16'd3;
    do_cmd(4'd6);
    do_wake();
    for (int i = 0; i < 15; i++) cyc(1'b1);
    cyc(1'b0);
    chk("R11 clamp busy at 15", 32'(busy_o), 32'd1);
    cyc(1'b1); cyc(1'b0);
    chk("R11 clamp done", 32'(mode_o), 32'd1);

    summary();
    $finish;
  end

endmodule